// File: doc/BRIEF.md
# Two-Wire Serial Memory Target Engine

This block is the target side of a two-wire serial memory. It samples the clock and data lines of the bus, which have already been synchronized to a fast system clock. It detects Start and Stop conditions and shifts in a control byte. It compares that byte with a fixed device code and with three board-level select straps. It then runs byte writes, current-address reads, random reads and sequential reads against a 16K x 8 synchronous RAM port. The block answers the host by asserting an open-drain pull-down enable on the data line.

A 14-bit address pointer is loaded from two address bytes, high byte first, and the top two bits of the high byte are discarded. Reads return the byte at the pointer and then advance it. A byte write is held until the host sends Stop. The block then issues a single RAM write strobe and advances the pointer. A busy window of `WRITE_CYCLES` system clocks follows each write. During that window the block acknowledges nothing, which lets a host poll for completion. Every byte of a read is taken from the RAM port registered one cycle earlier.

Top module: `eeprom_bus_target`

## Requirements
- R1: Reset leaves the pull-down released and the write strobe low. A falling data edge while the clock line is high is a Start, and it restarts control-byte reception from any state, even mid-byte. A rising data edge while the clock line is high is a Stop, and it returns the engine to idle.
- R2: The control byte is acknowledged only when bits [7:4] equal 4'b1010 and bits [3:1] equal `sel_strap`; bit 0 set to 1 means read and 0 means write. A mismatching control byte gets no acknowledge, and every later byte is ignored until the next Start.
- R3: After a write control byte, two address bytes follow, high byte first. Each is acknowledged. The pointer becomes {high[5:0], low}, and high[7:6] are ignored.
- R4: An acknowledge holds the data line low for the whole high phase of the ninth clock. The pull-down changes only in the system cycle after a clock-line falling edge is seen, or on a Start or Stop, so it never changes while the clock line is high.
- R5: A data byte after the address is acknowledged and written to RAM only when a Stop arrives. The write is one single-cycle strobe at the pointer address, and afterwards the pointer is that address plus one.
- R6: For `WRITE_CYCLES` system clocks after a write strobe, the engine acknowledges no byte, not even a matching control byte. After the window closes, a matching control byte is acknowledged again.
- R7: A read control byte is followed by the byte at the pointer, sent most significant bit first, and the pointer then advances by one.
- R8: A repeated Start after the address bytes keeps the loaded pointer, so a read control byte returns that location. A repeated Start after a data byte discards the pending write, and no strobe is issued.
- R9: In a read, an acknowledge from the host makes the engine send the next byte. The pointer wraps from 14'h3FFF to 14'h0000.
- R10: When the host does not acknowledge a read byte, the engine releases the data line and drives nothing until the next Start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Synchronized bus clock line |
| sda_in | input | 1 | Synchronized bus data line (resolved bus level) |
| sel_strap | input | 3 | Device select straps compared with control byte bits [3:1] |
| sda_pull | output | 1 | Open-drain enable: 1 pulls the data line low |
| mem_addr | output | 14 | RAM address, always the current pointer |
| mem_we | output | 1 | RAM write strobe, one cycle |
| mem_wdata | output | 8 | RAM write data |
| mem_rdata | input | 8 | RAM read data, registered one cycle after mem_addr |

## Verification
Control bytes are sent with a wrong device code, with wrong straps, and again without a Start while the engine is ignoring the bus. Together these show that both fields are compared and that a mismatch is latched until the next Start. A byte write whose high address byte has its top bits set, followed at once by an acknowledge poll, shows the address truncation, the deferred commit and the busy silence. A later poll shows that the window ends. Current, random, aborted-write and sequential reads that start at 14'h3FFE separate pointer holding from pointer advance and from wrap-around. Stops and repeated Starts injected mid-byte, plus bytes clocked after a host not-acknowledge, show which events reset the byte state and which are ignored.

// File: rtl/eeprom_bus_target.sv
module eeprom_bus_target #(
  parameter int          ADDR_W       = 14,
  parameter int          WRITE_CYCLES = 500,
  parameter logic [3:0]  DEV_CODE     = 4'b1010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic [2:0]        sel_strap,
  output logic              sda_pull,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata
);
  localparam int HI_W  = ADDR_W - 8;
  localparam int CNT_W = $clog2(WRITE_CYCLES + 1);

  typedef enum logic [2:0] {S_IDLE, S_CTRL, S_AHI, S_ALO, S_WDAT, S_RDAT, S_SKIP} st_t;

  st_t               st;
  logic              scl_q, sda_q;
  logic [3:0]        bit_cnt;
  logic [7:0]        sreg;
  logic [6:0]        tx;
  logic              rd_dir;
  logic [HI_W-1:0]   addr_hi;
  logic [ADDR_W-1:0] ptr;
  logic [7:0]        wbuf;
  logic              wpend, we_r;
  logic [CNT_W-1:0]  busy_cnt;

  wire scl_rise  = scl_in & ~scl_q;
  wire scl_fall  = ~scl_in & scl_q;
  wire start_det = scl_in & scl_q & sda_q & ~sda_in;
  wire stop_det  = scl_in & scl_q & ~sda_q & sda_in;
  wire busy      = busy_cnt != '0;
  wire ctrl_hit  = (sreg[7:4] == DEV_CODE) && (sreg[3:1] == sel_strap);
  wire rx_state  = (st == S_CTRL) || (st == S_AHI) || (st == S_ALO) || (st == S_WDAT);

  assign mem_addr  = ptr;
  assign mem_we    = we_r;
  assign mem_wdata = wbuf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_in;
      sda_q <= sda_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      busy_cnt <= '0;
    else if (we_r)
      busy_cnt <= CNT_W'(WRITE_CYCLES);
    else if (busy)
      busy_cnt <= busy_cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      bit_cnt  <= '0;
      sreg     <= '0;
      tx       <= '0;
      rd_dir   <= 1'b0;
      addr_hi  <= '0;
      ptr      <= '0;
      wbuf     <= '0;
      wpend    <= 1'b0;
      we_r     <= 1'b0;
      sda_pull <= 1'b0;
    end else begin
      we_r <= 1'b0;
      if (we_r)
        ptr <= ptr + 1'b1;
      if (start_det) begin
        st       <= S_CTRL;
        bit_cnt  <= '0;
        sda_pull <= 1'b0;
        wpend    <= 1'b0;
      end else if (stop_det) begin
        st       <= S_IDLE;
        bit_cnt  <= '0;
        sda_pull <= 1'b0;
        wpend    <= 1'b0;
        if (wpend) we_r <= 1'b1;
      end else if (rx_state) begin
        if (scl_rise) begin
          if (bit_cnt < 4'd8) begin
            sreg    <= {sreg[6:0], sda_in};
            bit_cnt <= bit_cnt + 4'd1;
          end else if (bit_cnt == 4'd8) begin
            bit_cnt <= 4'd9;
          end
        end else if (scl_fall) begin
          if (bit_cnt == 4'd8) begin
            case (st)
              S_CTRL: begin
                rd_dir <= sreg[0];
                if (ctrl_hit && !busy) sda_pull <= 1'b1;
                else                   st <= S_SKIP;
              end
              S_AHI: begin
                addr_hi  <= sreg[HI_W-1:0];
                sda_pull <= 1'b1;
              end
              S_ALO: begin
                ptr      <= {addr_hi, sreg};
                sda_pull <= 1'b1;
              end
              default: begin
                wbuf     <= sreg;
                wpend    <= 1'b1;
                sda_pull <= 1'b1;
              end
            endcase
          end else if (bit_cnt == 4'd9) begin
            bit_cnt  <= '0;
            sda_pull <= 1'b0;
            case (st)
              S_CTRL: begin
                if (rd_dir) begin
                  st       <= S_RDAT;
                  tx       <= mem_rdata[6:0];
                  sda_pull <= ~mem_rdata[7];
                end else begin
                  st <= S_AHI;
                end
              end
              S_AHI:   st <= S_ALO;
              default: st <= S_WDAT;
            endcase
          end
        end
      end else if (st == S_RDAT) begin
        if (scl_rise) begin
          if (bit_cnt < 4'd8)
            bit_cnt <= bit_cnt + 4'd1;
          else if (bit_cnt == 4'd8) begin
            if (sda_in) st <= S_SKIP;
            else        bit_cnt <= 4'd9;
          end
        end else if (scl_fall) begin
          if (bit_cnt >= 4'd1 && bit_cnt <= 4'd7) begin
            sda_pull <= ~tx[6];
            tx       <= {tx[5:0], 1'b0};
          end else if (bit_cnt == 4'd8) begin
            sda_pull <= 1'b0;
            ptr      <= ptr + 1'b1;
          end else if (bit_cnt == 4'd9) begin
            tx       <= mem_rdata[6:0];
            sda_pull <= ~mem_rdata[7];
            bit_cnt  <= '0;
          end
        end
      end
    end
  end

  AST_SDA_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_q && $past(scl_q)) |-> $stable(sda_pull)); // R4

  AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we); // R5

  AST_POINTER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mem_we) |-> (mem_addr == ADDR_W'($past(mem_addr) + 1'b1))); // R5

  AST_BUSY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_pull); // R6

  AST_STROBE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !busy); // R6

  AST_SKIP_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SKIP || st == S_IDLE) |-> !sda_pull); // R10
endmodule

// File: tb/tb_eeprom_bus_target.sv
module tb_eeprom_bus_target;
  localparam int CLK_P = 10;
  localparam int Q     = 4;
  localparam int WR    = 500;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] CW = {4'b1010, STRAP, 1'b0};
  localparam logic [7:0] CR = {4'b1010, STRAP, 1'b1};

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda_h = 1'b1;
  logic sda_pull, mem_we;
  logic [13:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;
  logic [7:0] ram [256];
  wire line = sda_h & ~sda_pull;

  int n_chk = 0, n_bad = 0, wr_cnt = 0;
  logic [13:0] last_wa;
  logic [7:0]  last_wd;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  eeprom_bus_target #(.ADDR_W(14), .WRITE_CYCLES(WR), .DEV_CODE(4'b1010)) dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(line), .sel_strap(STRAP),
    .sda_pull(sda_pull), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

  initial for (int i = 0; i < 256; i++) ram[i] = 8'(i * 37 + 11);

  always @(posedge clk) begin
    if (mem_we) ram[mem_addr[7:0]] <= mem_wdata ^ {2'b00, mem_addr[13:8]};
    mem_rdata <= ram[mem_addr[7:0]] ^ {2'b00, mem_addr[13:8]};
  end

  always @(negedge clk) if (mem_we) begin
    wr_cnt++;
    last_wa = mem_addr;
    last_wd = mem_wdata;
  end

  function automatic logic [7:0] exp_at(input logic [13:0] a);
    return ram[a[7:0]] ^ {2'b00, a[13:8]};
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_h = 1'b1; hold(Q); scl = 1'b1; hold(Q); sda_h = 1'b0; hold(Q); scl = 1'b0; hold(Q);
  endtask

  task automatic bus_stop();
    sda_h = 1'b0; hold(Q); scl = 1'b1; hold(Q); sda_h = 1'b1; hold(Q);
  endtask

  task automatic bit_tx(input logic b);
    sda_h = b; hold(Q); scl = 1'b1; hold(2*Q); scl = 1'b0; hold(Q);
  endtask

  task automatic bit_rx(output logic r, output logic held);
    logic r0;
    sda_h = 1'b1; hold(Q); scl = 1'b1; hold(1); r0 = line;
    hold(2*Q-1); r = line; held = (r0 == r); scl = 1'b0; hold(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked, output logic held);
    logic r;
    for (int i = 7; i >= 0; i--) bit_tx(b[i]);
    bit_rx(r, held);
    acked = !r;
  endtask

  task automatic recv_byte(input logic host_ack, output logic [7:0] d);
    logic r, h;
    for (int i = 7; i >= 0; i--) begin bit_rx(r, h); d[i] = r; end
    bit_tx(host_ack ? 1'b0 : 1'b1);
  endtask

  task automatic t_reset();
    hold(5); rst_n = 1'b1; hold(2);
    chk("R1 reset pull released", sda_pull, 0);
    chk("R1 reset strobe low", mem_we, 0);
  endtask

  task automatic t_mismatch();
    logic a, h;
    bus_start(); send_byte(8'hB0 | {4'b0, STRAP, 1'b0}, a, h);
    chk("R2 wrong device code nack", a, 0); bus_stop();
    bus_start(); send_byte({4'b1010, 3'b001, 1'b0}, a, h);
    chk("R2 wrong strap nack", a, 0);
    send_byte(CW, a, h);
    chk("R2 ignored until Start", a, 0); bus_stop();
  endtask

  task automatic t_byte_write();
    logic a, h;
    bus_start(); send_byte(CW, a, h);
    chk("R2 matching control ack", a, 1); chk("R4 ack held through high", h, 1);
    send_byte(8'hC1, a, h); chk("R3 high address ack", a, 1);
    send_byte(8'h23, a, h); chk("R3 low address ack", a, 1);
    send_byte(8'hA5, a, h); chk("R5 data ack", a, 1);
    chk("R5 no strobe before Stop", wr_cnt, 0);
    bus_stop(); hold(2);
    chk("R5 one strobe", wr_cnt, 1);
    chk("R3 top bits ignored", last_wa, 14'h0123);
    chk("R5 write data", last_wd, 8'hA5);
  endtask

  task automatic t_poll();
    logic a, h;
    bus_start(); send_byte(CW, a, h); chk("R6 busy control nack", a, 0); bus_stop();
    hold(WR + 50);
    bus_start(); send_byte(CW, a, h); chk("R6 ack after window", a, 1); bus_stop();
    hold(2); chk("R6 poll writes nothing", wr_cnt, 1);
  endtask

  task automatic t_current_read();
    logic a, h; logic [7:0] d;
    bus_start(); send_byte(CR, a, h); chk("R7 read control ack", a, 1);
    recv_byte(1'b0, d); bus_stop();
    chk("R5 pointer after write", d, exp_at(14'h0124));
    bus_start(); send_byte(CR, a, h); recv_byte(1'b0, d); bus_stop();
    chk("R7 pointer advance", d, exp_at(14'h0125));
  endtask

  task automatic set_addr(input logic [13:0] ad);
    logic a, h;
    bus_start(); send_byte(CW, a, h);
    send_byte({2'b00, ad[13:8]}, a, h); send_byte(ad[7:0], a, h);
  endtask

  task automatic t_random_read();
    logic a, h; logic [7:0] d;
    set_addr(14'h0123);
    bus_start(); send_byte(CR, a, h); recv_byte(1'b0, d); bus_stop();
    chk("R8 random read", d, 8'hA5);
    hold(2); chk("R8 no strobe on random read", wr_cnt, 1);
  endtask

  task automatic t_abort();
    logic a, h; logic [7:0] d, e;
    e = exp_at(14'h0200);
    set_addr(14'h0200); send_byte(8'h77, a, h);
    bus_start(); send_byte(CR, a, h); recv_byte(1'b0, d); bus_stop();
    chk("R8 aborted write keeps old data", d, e);
    hold(2); chk("R8 aborted write no strobe", wr_cnt, 1);
  endtask

  task automatic t_sequential();
    logic a, h; logic [7:0] d;
    set_addr(14'h3FFE);
    bus_start(); send_byte(CR, a, h);
    recv_byte(1'b1, d); chk("R9 seq byte 3FFE", d, exp_at(14'h3FFE));
    recv_byte(1'b1, d); chk("R9 seq byte 3FFF", d, exp_at(14'h3FFF));
    recv_byte(1'b1, d); chk("R9 seq wrap 0000", d, exp_at(14'h0000));
    recv_byte(1'b0, d); chk("R9 seq byte 0001", d, exp_at(14'h0001));
    bus_stop();
    bus_start(); send_byte(CR, a, h); recv_byte(1'b0, d); bus_stop();
    chk("R9 pointer after wrap", d, exp_at(14'h0002));
  endtask

  task automatic t_nack_release();
    logic a, h; logic [7:0] d;
    bus_start(); send_byte(CR, a, h); recv_byte(1'b0, d);
    chk("R7 read at 0003", d, exp_at(14'h0003));
    recv_byte(1'b0, d); chk("R10 line released after nack", d, 8'hFF);
    bus_start(); send_byte(CW, a, h); chk("R1 Start recovers", a, 1);
    bus_stop();
  endtask

  task automatic t_mid_byte();
    logic a, h; logic [7:0] d;
    bus_start(); bit_tx(1'b1); bit_tx(1'b0); bit_tx(1'b1); bit_tx(1'b0);
    bus_stop();
    bus_start(); send_byte(CW, a, h); chk("R1 after mid-byte Stop", a, 1);
    send_byte(8'h00, a, h);
    bit_tx(1'b0); bit_tx(1'b1);
    bus_start(); send_byte(CR, a, h); chk("R1 after mid-byte Start", a, 1);
    recv_byte(1'b0, d); bus_stop();
    chk("R1 partial address leaves pointer", d, exp_at(14'h0004));
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    t_reset();
    t_mismatch();
    t_byte_write();
    t_poll();
    t_current_read();
    t_random_read();
    t_abort();
    t_sequential();
    t_nack_release();
    t_mid_byte();
    hold(5);
    summary();
  end
endmodule